// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Result Pair Registers

This block is a sequential integer multiply/divide engine that sits beside the main ALU. A one-cycle `start` pulse hands it an operation code and two XLEN-bit register-file operands. It then works through the operation one step per clock. A multiply uses shift-and-add and a divide uses restoring shift-and-subtract long division. The result lands in a pair of dedicated registers, `hi` and `lo`, that the pipeline reads directly through the output ports. `busy` stays high from the cycle after an accepted start until the result pair is written, so the pipeline can stall on it.

A multiply writes the 2·XLEN-bit product, upper half to `hi` and lower half to `lo`. A divide writes the remainder to `hi` and the quotient to `lo`. Signed multiply widens both operands to 2·XLEN bits by sign extension and iterates over the widened multiplier. The loop stops on the first step that leaves the remaining multiplier at zero, so latency depends on the data. Signed divide runs on magnitudes and fixes the signs on writeback. Two flags report whether the result pair, read as a product, fits in one XLEN-bit word, unsigned or signed.

Top module: `muldiv_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `busy`, `hi` and `lo` become 0 after that edge.
- R2: `op` = 2'd1 (unsigned multiply) writes the unsigned 2·XLEN-bit product of `src_a` and `src_b`, with bits [2·XLEN-1:XLEN] to `hi` and bits [XLEN-1:0] to `lo`.
- R3: `op` = 2'd0 (signed multiply) treats both operands as two's complement and writes the signed product the same way. `lo` equals the `lo` of the unsigned multiply of the same operands.
- R4: A multiply keeps `busy` high for N cycles and writes `hi`/`lo` at the edge where `busy` falls. N is the bit length of the multiplier widened to 2·XLEN bits (zero-extended for op 1, sign-extended for op 0), with a minimum of 1.
- R5: `op` = 2'd3 (unsigned divide) writes `src_a / src_b` to `lo` and `src_a % src_b` to `hi`, after exactly XLEN busy cycles.
- R6: `op` = 2'd2 (signed divide) divides the operand magnitudes. The quotient is negated when the operand signs differ, and the remainder takes the sign of `src_a`. Results are truncated to XLEN bits, so the most negative value divided by -1 gives quotient 2^(XLEN-1) and remainder 0.
- R7: A divide with `src_b` = 0 keeps `busy` high for XLEN cycles and leaves `hi` and `lo` unchanged.
- R8: A `start` seen while `busy` is high is ignored. The running operation completes with its own operands and latency, and while `busy` is low `hi`/`lo` never change.
- R9: `mul_ovf_u` is 1 exactly when `hi` is nonzero.
- R10: `mul_ovf_s` is 1 exactly when `hi` differs from XLEN copies of `lo[XLEN-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only while `busy` is low) |
| op | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| src_a | input | XLEN | Multiplicand / dividend |
| src_b | input | XLEN | Multiplier / divisor |
| busy | output | 1 | Operation in progress |
| hi | output | XLEN | Upper product half or remainder |
| lo | output | XLEN | Lower product half or quotient |
| mul_ovf_u | output | 1 | Result pair does not fit an unsigned word |
| mul_ovf_s | output | 1 | Result pair does not fit a signed word |

## Verification
The bench builds the unit with XLEN = 32, the default, and its reference model uses 64-bit integers, so every product and quotient is checked at full width. This width reaches the full 64-step signed multiply on a negative multiplier, the one-step zero multiplier, and the most-negative-by-minus-one divide. It also reaches flag cases where only one of the two overflow flags is set. A hand-written set of corner operands is followed by a pseudo-random stream of mixed operations with shortened multipliers, so early exit is exercised at many lengths.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        MD_MULS = 2'd0,
        MD_MULU = 2'd1,
        MD_DIVS = 2'd2,
        MD_DIVU = 2'd3
    } md_op_e;

    typedef struct packed {
        logic is_div;
        logic is_signed;
    } md_ctl_t;

    function automatic md_ctl_t md_decode(md_op_e op);
        md_ctl_t c;
        c.is_div    = (op == MD_DIVS) || (op == MD_DIVU);
        c.is_signed = (op == MD_MULS) || (op == MD_DIVS);
        return c;
    endfunction

    function automatic logic md_sign_of(logic is_signed, logic msb);
        return is_signed & msb;
    endfunction

endpackage

// File: rtl/md_operand_prep.sv
module md_operand_prep
    import muldiv_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  md_op_e                op,
    input  logic [XLEN-1:0]       src_a,
    input  logic [XLEN-1:0]       src_b,
    output md_ctl_t               ctl,
    output logic [2*XLEN-1:0]     mul_a,
    output logic [2*XLEN-1:0]     mul_b,
    output logic [XLEN-1:0]       num_mag,
    output logic [XLEN-1:0]       den_mag,
    output logic                  q_neg,
    output logic                  r_neg
);
    logic neg_a;
    logic neg_b;

    always_comb begin
        ctl     = md_decode(op);
        neg_a   = md_sign_of(ctl.is_signed, src_a[XLEN-1]);
        neg_b   = md_sign_of(ctl.is_signed, src_b[XLEN-1]);
        // widen: sign fill for signed ops, zero fill otherwise
        mul_a   = {{XLEN{neg_a}}, src_a};
        mul_b   = {{XLEN{neg_b}}, src_b};
        num_mag = neg_a ? (XLEN'(0) - src_a) : src_a;
        den_mag = neg_b ? (XLEN'(0) - src_b) : src_b;
        q_neg   = neg_a ^ neg_b;
        r_neg   = neg_a;
    end
endmodule

// File: rtl/md_iter_engine.sv
module md_iter_engine
    import muldiv_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_req,
    input  md_ctl_t               ctl,
    input  logic [2*XLEN-1:0]     mul_a,
    input  logic [2*XLEN-1:0]     mul_b,
    input  logic [XLEN-1:0]       num_mag,
    input  logic [XLEN-1:0]       den_mag,
    input  logic                  q_neg,
    input  logic                  r_neg,
    output logic                  busy,
    output logic                  wr_en,
    output logic [XLEN-1:0]       wr_hi,
    output logic [XLEN-1:0]       wr_lo
);
    localparam int unsigned W2 = 2 * XLEN;
    localparam int unsigned CW = $clog2(XLEN + 1);

    // one register set shared by both algorithms:
    //   multiply: acc = product, opd = multiplicand, aux = multiplier
    //   divide:   acc = running dividend, opd = divisor, aux = quotient
    typedef struct packed {
        logic          busy;
        logic          is_div;
        logic          q_neg;
        logic          r_neg;
        logic          skip_wr;
        logic [CW-1:0] cnt;
        logic [W2-1:0] acc;
        logic [W2-1:0] opd;
        logic [W2-1:0] aux;
    } eng_state_t;

    eng_state_t    st_q, st_d;
    logic          last;
    logic [W2-1:0] dsh;
    logic          ge;
    logic [CW-1:0] cnt_inc;
    logic [XLEN-1:0] quo, rem;

    always_comb begin
        st_d    = st_q;
        last    = 1'b0;
        dsh     = st_q.opd >> 1;
        ge      = (st_q.acc >= dsh);
        cnt_inc = st_q.cnt + 1'b1;
        if (!st_q.busy) begin
            if (load_req) begin
                st_d.busy    = 1'b1;
                st_d.is_div  = ctl.is_div;
                st_d.q_neg   = q_neg;
                st_d.r_neg   = r_neg;
                st_d.skip_wr = (den_mag == '0);
                st_d.cnt     = '0;
                if (ctl.is_div) begin
                    st_d.acc = {{XLEN{1'b0}}, num_mag};
                    st_d.opd = {den_mag, {XLEN{1'b0}}};
                    st_d.aux = '0;
                end else begin
                    st_d.acc = '0;
                    st_d.opd = mul_a;
                    st_d.aux = mul_b;
                end
            end
        end else if (st_q.is_div) begin
            st_d.opd = dsh;
            st_d.acc = ge ? (st_q.acc - dsh) : st_q.acc;
            st_d.aux = {st_q.aux[W2-2:0], ge};
            st_d.cnt = cnt_inc;
            last     = (cnt_inc == CW'(XLEN));
        end else begin
            st_d.acc = st_q.aux[0] ? (st_q.acc + st_q.opd) : st_q.acc;
            st_d.opd = st_q.opd << 1;
            st_d.aux = st_q.aux >> 1;
            last     = (st_d.aux == '0);
        end
        if (last) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        quo   = st_d.aux[XLEN-1:0];
        rem   = st_d.acc[XLEN-1:0];
        wr_en = st_q.busy & last & ~(st_q.is_div & st_q.skip_wr);
        if (st_q.is_div) begin
            wr_lo = st_q.q_neg ? (XLEN'(0) - quo) : quo;
            wr_hi = st_q.r_neg ? (XLEN'(0) - rem) : rem;
        end else begin
            wr_lo = st_d.acc[XLEN-1:0];
            wr_hi = st_d.acc[W2-1:XLEN];
        end
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/md_hilo_regs.sv
module md_hilo_regs #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_hi,
    input  logic [XLEN-1:0] wr_lo,
    output logic [XLEN-1:0] hi,
    output logic [XLEN-1:0] lo,
    output logic            ovf_u,
    output logic            ovf_s
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hi <= '0;
            lo <= '0;
        end else if (wr_en) begin
            hi <= wr_hi;
            lo <= wr_lo;
        end
    end

    assign ovf_u = |hi;
    assign ovf_s = (hi != {XLEN{lo[XLEN-1]}});
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            busy,
    output logic [XLEN-1:0] hi,
    output logic [XLEN-1:0] lo,
    output logic            mul_ovf_u,
    output logic            mul_ovf_s
);
    localparam int unsigned W2 = 2 * XLEN;

    md_ctl_t         ctl;
    logic [W2-1:0]   mul_a, mul_b;
    logic [XLEN-1:0] num_mag, den_mag;
    logic            q_neg, r_neg;
    logic            wr_en;
    logic [XLEN-1:0] wr_hi, wr_lo;

    md_operand_prep #(.XLEN(XLEN)) i_prep (
        .op      (md_op_e'(op)),
        .src_a   (src_a),
        .src_b   (src_b),
        .ctl     (ctl),
        .mul_a   (mul_a),
        .mul_b   (mul_b),
        .num_mag (num_mag),
        .den_mag (den_mag),
        .q_neg   (q_neg),
        .r_neg   (r_neg)
    );

    md_iter_engine #(.XLEN(XLEN)) i_engine (
        .clk      (clk),
        .rst      (rst),
        .load_req (start),
        .ctl      (ctl),
        .mul_a    (mul_a),
        .mul_b    (mul_b),
        .num_mag  (num_mag),
        .den_mag  (den_mag),
        .q_neg    (q_neg),
        .r_neg    (r_neg),
        .busy     (busy),
        .wr_en    (wr_en),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo)
    );

    md_hilo_regs #(.XLEN(XLEN)) i_hilo (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .wr_hi (wr_hi),
        .wr_lo (wr_lo),
        .hi    (hi),
        .lo    (lo),
        .ovf_u (mul_ovf_u),
        .ovf_s (mul_ovf_s)
    );
endmodule

// File: rtl/md_checker.sv
module md_checker #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            op_is_div,
    input logic            busy,
    input logic [XLEN-1:0] hi,
    input logic [XLEN-1:0] lo,
    input logic            mul_ovf_u,
    input logic            mul_ovf_s
);
    localparam int unsigned CW = $clog2(2 * XLEN + 2);

    logic [CW-1:0] run_cnt;
    logic          run_div;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            run_div <= 1'b0;
        end else if (start && !busy) begin
            run_cnt <= '0;
            run_div <= op_is_div;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R1: reset clears state
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!busy && hi == '0 && lo == '0));

    // R4: accepted start raises busy
    p_start_sets_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R4: multiply length within 1..2*XLEN
    p_mul_length_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !run_div) |-> (run_cnt >= CW'(1) && run_cnt <= CW'(2 * XLEN)));

    // R5: divide takes exactly XLEN cycles
    p_div_length_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && run_div) |-> (run_cnt == CW'(XLEN)));

    // R8: result pair holds while idle, whatever start does
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(hi) && $stable(lo)));

    // R10: signed-only overflow with zero upper half needs a negative low half
    p_ovf_cross_r10: assert property (@(posedge clk) disable iff (rst)
        (mul_ovf_s && !mul_ovf_u) |-> lo[XLEN-1]);
endmodule

bind muldiv_unit md_checker #(.XLEN(XLEN)) i_md_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_is_div (op[1]),
    .busy      (busy),
    .hi        (hi),
    .lo        (lo),
    .mul_ovf_u (mul_ovf_u),
    .mul_ovf_s (mul_ovf_s)
);

// File: tb/test_muldiv_unit.sv
module test_muldiv_unit;
    localparam int XLEN = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [31:0] src_a = '0, src_b = '0;
    logic        busy;
    logic [31:0] hi, lo;
    logic        mul_ovf_u, mul_ovf_s;

    muldiv_unit #(.XLEN(XLEN)) i_muldiv_unit (
        .clk(clk), .rst(rst), .start(start), .op(op), .src_a(src_a), .src_b(src_b),
        .busy(busy), .hi(hi), .lo(lo), .mul_ovf_u(mul_ovf_u), .mul_ovf_s(mul_ovf_s)
    );

    always #4 clk = ~clk;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    cmp_on = 1'b0;
    bit    finished = 1'b0;
    string cur_tag = "R1";

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    task automatic ref_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] rh, output logic [31:0] rl,
                          output int steps, output bit wr);
        longint      x, y, p;
        logic [63:0] yb;
        logic [31:0] ma, mb, q, r;
        wr = 1'b1;
        rh = '0; rl = '0;
        if (!o[1]) begin
            if (o == 2'd0) begin
                x = longint'($signed(a)); y = longint'($signed(b));
            end else begin
                x = longint'({32'd0, a}); y = longint'({32'd0, b});
            end
            p = x * y;
            rh = p[63:32]; rl = p[31:0];
            yb = y;
            steps = 1;
            for (int i = 63; i >= 0; i--) begin
                if (yb[i]) begin steps = i + 1; break; end
            end
        end else begin
            steps = XLEN;
            if (b == 0) begin
                wr = 1'b0;
            end else if (o == 2'd3) begin
                rl = a / b; rh = a % b;
            end else begin
                ma = a[31] ? -a : a;
                mb = b[31] ? -b : b;
                q = ma / mb; r = ma % mb;
                rl = (a[31] ^ b[31]) ? -q : q;
                rh = a[31] ? -r : r;
            end
        end
    endtask

    bit          m_busy = 0;
    int          m_rem = 0;
    logic [31:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
    bit          p_wr = 0;

    always @(posedge clk) begin
        int st;
        if (rst) begin
            m_busy = 0; m_hi = '0; m_lo = '0; m_rem = 0;
        end else if (!m_busy && start) begin
            ref_op(op, src_a, src_b, p_hi, p_lo, st, p_wr);
            m_busy = 1; m_rem = st;
        end else if (m_busy) begin
            m_rem--;
            if (m_rem == 0) begin
                m_busy = 0;
                if (p_wr) begin m_hi = p_hi; m_lo = p_lo; end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cur_tag, "busy", {31'd0, busy}, {31'd0, m_busy});
            chk(cur_tag, "hi", hi, m_hi);
            chk(cur_tag, "lo", lo, m_lo);
            chk("R9", "mul_ovf_u", {31'd0, mul_ovf_u}, {31'd0, (m_hi != 0)});
            chk("R10", "mul_ovf_s", {31'd0, mul_ovf_s}, {31'd0, (m_hi != {32{m_lo[31]}})});
        end
    end

    // ---------------- stimulus ----------------
    task automatic run_op(string tag, logic [1:0] o, logic [31:0] a, logic [31:0] b,
                          logic [31:0] eh, logic [31:0] el, int esteps);
        int cnt = 0;
        cur_tag = tag;
        start = 1'b1; op = o; src_a = a; src_b = b;
        @(negedge clk);
        start = 1'b0;
        while (busy && cnt < 200) begin
            cnt++;
            @(negedge clk);
        end
        chk(tag, "hi", hi, eh);
        chk(tag, "lo", lo, el);
        chk(tag, "busy cycles", 32'(cnt), 32'(esteps));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] s, a, b, eh, el;
        logic [1:0]  o;
        int          st;
        bit          wr;
        repeat (3) @(negedge clk);
        chk("R1", "busy after reset", {31'd0, busy}, 32'd0);
        chk("R1", "hi after reset", hi, 32'd0);
        chk("R1", "lo after reset", lo, 32'd0);
        rst = 1'b0;
        cmp_on = 1'b1;
        @(negedge clk);

        // R2 unsigned multiply
        run_op("R2", 2'd1, 32'd13, 32'd11, 32'd0, 32'd143, 4);
        run_op("R2", 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0000_0001, 32);
        // R3 signed multiply: -3 * 5 and 5 * -3 (negative multiplier runs full width)
        run_op("R3", 2'd0, 32'hFFFF_FFFD, 32'd5, 32'hFFFF_FFFF, 32'hFFFF_FFF1, 3);
        run_op("R3", 2'd0, 32'd5, 32'hFFFF_FFFD, 32'hFFFF_FFFF, 32'hFFFF_FFF1, 64);
        run_op("R3", 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd1, 64);
        // R4 zero multiplier finishes in one step
        run_op("R4", 2'd1, 32'h1234_5678, 32'd0, 32'd0, 32'd0, 1);
        run_op("R4", 2'd0, 32'd7, 32'h4000_0000, 32'h1, 32'hC000_0000, 31);
        // R9/R10 flag cases
        run_op("R9", 2'd1, 32'h0001_0000, 32'h0001_0000, 32'd1, 32'd0, 17);
        chk("R9", "ovf_u on 2^32", {31'd0, mul_ovf_u}, 32'd1);
        run_op("R10", 2'd1, 32'h8000_0000, 32'd1, 32'd0, 32'h8000_0000, 1);
        chk("R10", "ovf_s only", {31'd0, mul_ovf_s}, 32'd1);
        chk("R9", "ovf_u clear", {31'd0, mul_ovf_u}, 32'd0);
        run_op("R10", 2'd0, 32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
        chk("R10", "ovf_s clear on -1", {31'd0, mul_ovf_s}, 32'd0);
        // R5 unsigned divide
        run_op("R5", 2'd3, 32'd100, 32'd7, 32'd2, 32'd14, 32);
        run_op("R5", 2'd3, 32'hFFFF_FFFF, 32'd1, 32'd0, 32'hFFFF_FFFF, 32);
        run_op("R5", 2'd3, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'd0, 32);
        // R6 signed divide
        run_op("R6", 2'd2, 32'hFFFF_FFF9, 32'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFD, 32);
        run_op("R6", 2'd2, 32'd7, 32'hFFFF_FFFE, 32'd1, 32'hFFFF_FFFD, 32);
        run_op("R6", 2'd2, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'd3, 32);
        run_op("R6", 2'd2, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0, 32'h8000_0000, 32);
        // R7 divide by zero leaves pair unchanged
        run_op("R7", 2'd1, 32'd6, 32'd9, 32'd0, 32'd54, 4);
        run_op("R7", 2'd2, 32'd77, 32'd0, 32'd0, 32'd54, 32);
        run_op("R7", 2'd3, 32'hFFFF_FFFF, 32'd0, 32'd0, 32'd54, 32);

        // R8 start while busy is ignored
        cur_tag = "R8";
        start = 1'b1; op = 2'd3; src_a = 32'd100; src_b = 32'd7;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; op = 2'd1; src_a = 32'hFFFF_FFFF; src_b = 32'hFFFF_FFFF;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        chk("R8", "lo kept first op", lo, 32'd14);
        chk("R8", "hi kept first op", hi, 32'd2);
        repeat (3) @(negedge clk);
        chk("R8", "no second op after", {31'd0, busy}, 32'd0);

        // mixed pseudo-random stream, expectations from the model routine
        s = 32'h2545_F491;
        for (int k = 0; k < 60; k++) begin
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            o = s[1:0];
            a = s ^ 32'h9E37_79B9;
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            b = s[2] ? (s >> s[7:3]) : s;
            ref_op(o, a, b, eh, el, st, wr);
            if (!wr) begin eh = hi; el = lo; end
            run_op(o == 2'd0 ? "R3" : o == 2'd1 ? "R2" : o == 2'd2 ? "R6" : "R5",
                   o, a, b, eh, el, st);
        end

        summary();
    end
endmodule